// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides which clock domains of a small microcontroller are running. Software writes a mode code into a request register. The controller then moves between normal run and four reduced-activity states, and it drives four enables: one for the CPU clock, one for the peripheral clock, one for the display (LCD) clock and one for the main oscillator. When a halted state ends, it raises a single-cycle wake event towards the CPU. At the same time the hardware clears the request register, so software finds it back at zero.

Each halted state has its own set of wake sources. Idle ends on any enabled interrupt request or on any of the external interrupt lines. Sleep and power-down respond only to the external interrupt lines. Sleep keeps the oscillator and the display clock running. Power-down stops the oscillator as well, so on wake the controller first turns the oscillator back on. It then waits until the oscillator-stable indication has been held for a programmable number of cycles, and only after that does it release the CPU. An asynchronous reset returns the controller to run from any state. The controller runs on an always-on clock. The external interrupt lines enter it through a synchronizer whose depth is a parameter.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is low, and right after it is released, all four enables are 1, `mode_q` is 0 and `wake_evt` is 0.
- R2: On a clock edge with `req_wr` high, a `req_mode` code is accepted. The codes are 0 = run, 1 = peripheral-gated run, 2 = idle, 3 = sleep and 4 = power-down. An accepted code appears on `mode_q`, and the enables change at that same edge. Codes 5 to 7 change neither `mode_q` nor the enables.
- R3: The enables, in the order cpu/per/lcd/osc, are: run 1111, peripheral-gated run 1011, idle 0111, sleep 0011, power-down 0000, and oscillator warm-up 0001.
- R4: In idle, `int_req` high at an edge returns the controller to run at that edge. A high level on any bit of `ext_irq` does the same, but only after SYNC_STAGES more edges.
- R5: In sleep and in power-down, `int_req` has no effect. Only `ext_irq` (through the synchronizer) ends these states. Sleep returns directly to run.
- R6: When power-down ends, the controller enters warm-up with only `osc_en` set. It returns to run after `osc_stable` has been sampled high on `osc_wait`+1 consecutive edges. A low sample restarts the count.
- R7: `wake_evt` is high for exactly one cycle at each return to run from idle, sleep or warm-up. `mode_q` reads 0 in that same cycle.
- R8: A `req_wr` while the CPU clock is gated (idle, sleep, power-down, warm-up) is ignored.
- R9: Asserting `rst_n` low returns the controller to run asynchronously, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | Mode-request register write strobe |
| req_mode | input | 3 | Mode code to write |
| osc_wait | input | CNT_W | Warm-up length minus one, in cycles of stable oscillator |
| int_req | input | 1 | Any enabled interrupt request (idle wake) |
| ext_irq | input | N_EXT | External interrupt lines, active high |
| osc_stable | input | 1 | Oscillator-stable indication |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| lcd_clk_en | output | 1 | Display clock enable |
| osc_en | output | 1 | Main oscillator enable |
| wake_evt | output | 1 | One-cycle wake event to the CPU |
| mode_q | output | 3 | Current content of the mode-request register |

## Verification
Two functions can land on the same edge: the hardware clear of the request register on wake, and the wake event itself. A third case is an interrupt request that arrives during sleep, where it must be ignored. The bench drives `int_req` while the controller sleeps and checks that the enables and `mode_q` stay unchanged. In warm-up it also drops `osc_stable` partway through the count, to see whether the restart collides with the exit. A scoreboard queue holds the exact cycle at which each wake event is predicted. The monitor pops one entry for every pulse it sees and judges it by cycle number. In that same cycle it also checks that `mode_q` has already been cleared.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] MODE_RUN   = 3'd0;
   localparam logic [MODE_W-1:0] MODE_PGATE = 3'd1;
   localparam logic [MODE_W-1:0] MODE_IDLE  = 3'd2;
   localparam logic [MODE_W-1:0] MODE_SLEEP = 3'd3;
   localparam logic [MODE_W-1:0] MODE_PDOWN = 3'd4;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_PGATE = 3'd1,
      ST_IDLE  = 3'd2,
      ST_SLEEP = 3'd3,
      ST_PDOWN = 3'd4,
      ST_WARM  = 3'd5
   } pwr_state_t;

   typedef struct packed {
      logic cpu;
      logic per;
      logic lcd;
      logic osc;
   } clk_en_t;
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
   parameter int N_EXT  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] irq_raw,
   output logic             wake_any
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("pwr_wake_sync: STAGES must be 0..4");
      end
      if (N_EXT < 1) begin : g_bad_next
         $error("pwr_wake_sync: N_EXT must be at least 1");
      end

      if (STAGES == 0) begin : g_direct
         assign wake_any = |irq_raw;
      end else begin : g_pipe
         logic [N_EXT-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       stage_q[s] <= '0;
               else if (s == 0)  stage_q[s] <= irq_raw;
               else              stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign wake_any = |stage_q[STAGES-1];

         // R4: a quiet input for a whole cycle leaves the last stage without new activity
         p_sync_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (STAGES == 1 && irq_raw == '0) |=> !wake_any);
      end
   endgenerate
endmodule

// File: rtl/pwr_osc_timer.sv
module pwr_osc_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             stable,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_w
         $error("pwr_osc_timer: CNT_W must be 1..24");
      end
   endgenerate

   assign done = active && stable && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (!active || !stable)      cnt_q <= '0;
      else if (cnt_q != limit)          cnt_q <= cnt_q + 1'b1;
   end

   // R6: a low stable sample always restarts the count
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !stable) |=> (cnt_q == '0));
   // R6: the count never passes the programmed limit while the limit is held
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $stable(limit) && cnt_q <= limit) |=> (cnt_q <= limit));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic [MODE_W-1:0] req_mode,
   input  logic              int_req,
   input  logic              ext_wake,
   input  logic              osc_done,
   output pwr_state_t        state_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              wake_evt
);
   pwr_state_t        state_d;
   logic [MODE_W-1:0] mode_d;
   logic              wake_d;
   logic              wr_ok;

   assign wr_ok = req_wr && (state_q == ST_RUN || state_q == ST_PGATE);

   always_comb begin
      state_d = state_q;
      mode_d  = mode_q;
      wake_d  = 1'b0;
      unique case (state_q)
         ST_RUN, ST_PGATE: begin
            if (wr_ok) begin
               mode_d = req_mode;
               unique case (req_mode)
                  MODE_RUN:   state_d = ST_RUN;
                  MODE_PGATE: state_d = ST_PGATE;
                  MODE_IDLE:  state_d = ST_IDLE;
                  MODE_SLEEP: state_d = ST_SLEEP;
                  MODE_PDOWN: state_d = ST_PDOWN;
                  default:    mode_d  = mode_q;
               endcase
            end
         end
         ST_IDLE:  if (int_req || ext_wake) begin
            state_d = ST_RUN; mode_d = MODE_RUN; wake_d = 1'b1;
         end
         ST_SLEEP: if (ext_wake) begin
            state_d = ST_RUN; mode_d = MODE_RUN; wake_d = 1'b1;
         end
         ST_PDOWN: if (ext_wake) state_d = ST_WARM;
         ST_WARM:  if (osc_done) begin
            state_d = ST_RUN; mode_d = MODE_RUN; wake_d = 1'b1;
         end
         default: begin
            state_d = ST_RUN; mode_d = MODE_RUN;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_RUN;
         mode_q   <= MODE_RUN;
         wake_evt <= 1'b0;
      end else begin
         state_q  <= state_d;
         mode_q   <= mode_d;
         wake_evt <= wake_d;
      end
   end

   // R8: a write while halted leaves the request register untouched
   p_halted_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && (state_q == ST_IDLE || state_q == ST_SLEEP || state_q == ST_PDOWN ||
                  state_q == ST_WARM) && !int_req && !ext_wake && !osc_done) |=> $stable(mode_q));
   // R5: interrupt requests alone never end sleep
   p_sleep_int_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && !ext_wake) |=> (state_q == ST_SLEEP));
   // R4: idle ends at the edge that sees an interrupt request
   p_idle_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && int_req) |=> (state_q == ST_RUN && wake_evt));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int N_EXT       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic [MODE_W-1:0] req_mode,
   input  logic [CNT_W-1:0]  osc_wait,
   input  logic              int_req,
   input  logic [N_EXT-1:0]  ext_irq,
   input  logic              osc_stable,
   output logic              cpu_clk_en,
   output logic              per_clk_en,
   output logic              lcd_clk_en,
   output logic              osc_en,
   output logic              wake_evt,
   output logic [MODE_W-1:0] mode_q
);
   pwr_state_t state_q;
   logic       ext_wake;
   logic       osc_done;
   clk_en_t    en;

   pwr_wake_sync #(.N_EXT(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .irq_raw(ext_irq), .wake_any(ext_wake));

   pwr_osc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .active(state_q == ST_WARM),
      .stable(osc_stable), .limit(osc_wait), .done(osc_done));

   pwr_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_mode(req_mode),
      .int_req(int_req), .ext_wake(ext_wake), .osc_done(osc_done),
      .state_q(state_q), .mode_q(mode_q), .wake_evt(wake_evt));

   always_comb begin
      unique case (state_q)
         ST_RUN:   en = '{cpu:1'b1, per:1'b1, lcd:1'b1, osc:1'b1};
         ST_PGATE: en = '{cpu:1'b1, per:1'b0, lcd:1'b1, osc:1'b1};
         ST_IDLE:  en = '{cpu:1'b0, per:1'b1, lcd:1'b1, osc:1'b1};
         ST_SLEEP: en = '{cpu:1'b0, per:1'b0, lcd:1'b1, osc:1'b1};
         ST_PDOWN: en = '{cpu:1'b0, per:1'b0, lcd:1'b0, osc:1'b0};
         ST_WARM:  en = '{cpu:1'b0, per:1'b0, lcd:1'b0, osc:1'b1};
         default:  en = '{cpu:1'b1, per:1'b1, lcd:1'b1, osc:1'b1};
      endcase
   end

   assign cpu_clk_en = en.cpu;
   assign per_clk_en = en.per;
   assign lcd_clk_en = en.lcd;
   assign osc_en     = en.osc;

   // R6: the CPU clock never restarts in the cycle after the oscillator was off
   p_no_cpu_after_osc_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |=> !cpu_clk_en);
   // R7: the wake event is a single-cycle pulse
   p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> !wake_evt);
   // R7: the request register is already clear when the wake event is seen
   p_wake_clears_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |-> (mode_q == MODE_RUN && cpu_clk_en));
   // R3: the display clock is only off while the CPU clock is off
   p_lcd_off_cpu_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_clk_en |-> !cpu_clk_en);
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
   localparam int SYNC = 2;
   localparam int W    = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_wr = 1'b0;
   logic [2:0] req_mode = 3'd0;
   logic [7:0] osc_wait = 8'(W);
   logic       int_req = 1'b0;
   logic [3:0] ext_irq = 4'd0;
   logic       osc_stable = 1'b1;
   logic       cpu_clk_en, per_clk_en, lcd_clk_en, osc_en, wake_evt;
   logic [2:0] mode_q;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int exp_q[$];

   pwr_seq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_mode(req_mode),
      .osc_wait(osc_wait), .int_req(int_req), .ext_irq(ext_irq),
      .osc_stable(osc_stable), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .lcd_clk_en(lcd_clk_en), .osc_en(osc_en), .wake_evt(wake_evt), .mode_q(mode_q));

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ens();
      return {cpu_clk_en, per_clk_en, lcd_clk_en, osc_en};
   endfunction

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(input logic [2:0] code);
      req_wr = 1'b1; req_mode = code;
      tick();
      req_wr = 1'b0;
   endtask

   task automatic ext_pulse(input int bitn);
      ext_irq[bitn] = 1'b1;
      tick();
      ext_irq = '0;
   endtask

   // monitor: every wake pulse must match the next predicted cycle
   always @(negedge clk) begin
      if (rst_n && wake_evt) begin
         if (exp_q.size() == 0) chk("R7 unexpected wake cycle", cyc, -1);
         else chk("R7 wake cycle", cyc, exp_q.pop_front());
         chk("R7 mode_q clear at wake", int'(mode_q), 0);
      end
   end

   initial begin
      #5000000;
      chk("watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #3;
      chk("R1 enables in reset", ens(), 15);
      chk("R1 mode_q in reset", int'(mode_q), 0);
      tick(2);
      rst_n = 1'b1;
      tick();
      chk("R1 enables after reset", ens(), 15);
      chk("R1 wake_evt after reset", int'(wake_evt), 0);

      wr(3'd5);
      chk("R2 invalid code mode_q", int'(mode_q), 0);
      chk("R2 invalid code enables", ens(), 15);
      wr(3'd1);
      chk("R2 peripheral-gated mode_q", int'(mode_q), 1);
      chk("R3 peripheral-gated enables", ens(), 4'b1011);
      wr(3'd0);
      chk("R2 back to run", ens(), 15);

      // idle, woken by int_req
      wr(3'd2);
      chk("R3 idle enables", ens(), 4'b0111);
      wr(3'd0);
      chk("R8 write in idle ignored enables", ens(), 4'b0111);
      chk("R8 write in idle ignored mode_q", int'(mode_q), 2);
      int_req = 1'b1;
      exp_q.push_back(cyc + 1);
      tick();
      int_req = 1'b0;
      chk("R4 idle int_req wake enables", ens(), 15);
      chk("R7 wake pulse high", int'(wake_evt), 1);
      tick();
      chk("R7 wake pulse one cycle", int'(wake_evt), 0);

      // idle, woken by external line
      wr(3'd2);
      exp_q.push_back(cyc + SYNC + 1);
      ext_pulse(2);
      tick(SYNC - 1);
      chk("R4 idle held during sync", int'(cpu_clk_en), 0);
      tick();
      chk("R4 idle ext wake", ens(), 15);
      tick(3);

      // sleep: int_req ignored, ext wakes
      wr(3'd3);
      chk("R3 sleep enables", ens(), 4'b0011);
      int_req = 1'b1;
      tick(2);
      int_req = 1'b0;
      tick();
      chk("R5 int_req ignored in sleep", ens(), 4'b0011);
      chk("R5 mode_q kept in sleep", int'(mode_q), 3);
      exp_q.push_back(cyc + SYNC + 1);
      ext_pulse(0);
      tick(SYNC);
      chk("R5 sleep ext wake", ens(), 15);
      tick(3);

      // power-down, oscillator already stable
      wr(3'd4);
      chk("R3 power-down enables", ens(), 4'b0000);
      int_req = 1'b1;
      tick();
      int_req = 1'b0;
      chk("R5 int_req ignored in power-down", ens(), 4'b0000);
      exp_q.push_back(cyc + SYNC + 1 + W + 1);
      ext_pulse(3);
      tick(SYNC);
      chk("R6 warm-up enables", ens(), 4'b0001);
      tick(W);
      chk("R6 still warming", int'(cpu_clk_en), 0);
      tick();
      chk("R6 run after warm-up", ens(), 15);
      tick(3);

      // power-down, oscillator unstable then interrupted count
      osc_stable = 1'b0;
      wr(3'd4);
      ext_pulse(1);
      tick(SYNC + 3);
      chk("R6 waits for osc_stable", ens(), 4'b0001);
      osc_stable = 1'b1;
      tick(2);
      osc_stable = 1'b0;
      tick();
      osc_stable = 1'b1;
      exp_q.push_back(cyc + W + 1);
      tick(W);
      chk("R6 count restarted after drop", int'(cpu_clk_en), 0);
      tick();
      chk("R6 run after restarted count", ens(), 15);
      tick(2);

      // asynchronous reset out of power-down
      wr(3'd4);
      chk("R9 in power-down", ens(), 0);
      #2 rst_n = 1'b0;
      #1;
      chk("R9 async reset enables", ens(), 15);
      chk("R9 async reset mode_q", int'(mode_q), 0);
      tick();
      rst_n = 1'b1;
      tick(2);
      chk("R7 all predicted wakes seen", exp_q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule